// File: doc/BRIEF.md
# Transceiver Reset Handshake Sequencer

This block sequences the reset of a multi-channel serial PHY. It has one transmit path and one receive path, and each path serves every lane of its direction. Each path has a four-phase handshake. The requester raises a reset request, and the block answers with an acknowledge. The requester then drops the request, and the block drops the acknowledge and starts releasing the path. A ready flag goes high once the release conditions are met.

On the transmit side the release waits for the lanes to report they have settled. When forward error correction is on, the block then raises a marker-start output, which tells the transmitter to emit alignment markers. The block waits for a marker-done reply, meaning at least two markers have left, and only then declares transmit ready. On the receive side the release waits for the lanes to settle and for clock-data recovery to lock. A later loss of lock withdraws receive ready until lock returns.

Every handshake and status input is asynchronous to the block clock and passes through a synchronizer first. Each output is a register. An input change therefore reaches the outputs exactly three clock edges later with the default two-stage synchronizer.

Top module: `xcvr_rst_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, every output is 0 until a request arrives.
- R2: A path's acknowledge rises on the third clock edge after its request rises (not on the second), and stays high as long as the request is held.
- R3: A path's acknowledge falls on the third clock edge after its request falls, and stays low as long as the request stays low.
- R4: With error correction off, `tx_ready` rises one edge after `tx_rst_ack` falls if `tx_settled` is already high. Otherwise it rises on the third edge after `tx_settled` rises. It is never high together with `tx_rst_ack`.
- R5: With error correction on, the edge that would raise `tx_ready` raises `mark_start` instead, and `tx_ready` stays 0 while `mark_start` is 1.
- R6: `mark_start` stays high until `mark_done` has been high for three edges. On that edge `mark_start` clears and `tx_ready` rises.
- R7: While `mark_done` is still high, no new `mark_start` is raised. `mark_start` rises on the third edge after `mark_done` falls.
- R8: A request that arrives while a path is ready clears ready and raises acknowledge on the same edge, three edges after the request.
- R9: `rx_ready` rises only when `rx_settled` and `cdr_lock` are both high after `rx_rst_ack` has fallen. It rises three edges after the later of the two.
- R10: Losing `cdr_lock` while receive is ready clears `rx_ready` three edges later. Regaining lock sets it again three edges later.
- R11: The two paths are independent. A handshake on one path leaves the other path's acknowledge and ready unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer itself |
| fec_en | input | 1 | Error correction enabled, quasi-static (1 adds the marker handshake) |
| tx_rst_req | input | 1 | Transmit reset request, asynchronous |
| tx_settled | input | 1 | Transmit lanes and datapath have left reset, asynchronous |
| mark_done | input | 1 | At least two alignment markers sent since `mark_start`, asynchronous |
| rx_rst_req | input | 1 | Receive reset request, asynchronous |
| rx_settled | input | 1 | Receive lanes and datapath have left reset, asynchronous |
| cdr_lock | input | 1 | Clock-data recovery locked, asynchronous |
| tx_rst_ack | output | 1 | Transmit path held in reset |
| tx_ready | output | 1 | Transmit path ready for data |
| mark_start | output | 1 | Begin sending alignment markers |
| rx_rst_ack | output | 1 | Receive path held in reset |
| rx_ready | output | 1 | Receive data valid on the parallel side |

## Verification
The properties assume that requesters obey the four-phase rule and hold a request until its acknowledge has risen. They also assume that `mark_done` rises only while `mark_start` is high and falls only after `mark_start` has cleared, and that `fec_en` is steady while a transmit handshake is running. The stimulus changes one input per step, always one clock phase away from the active edge, and holds every level for at least the three-edge synchronizer latency. It changes `fec_en` only while the transmit path is idle or ready, and waits longer than that latency afterwards.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE_RESET,
        ST_ACK,
        ST_RELEASE,
        ST_AM_WAIT,
        ST_READY
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       ack;
        logic       ready;
        logic       mark_start;
    } tx_regs_t;

    typedef struct packed {
        seq_state_e state;
        logic       ack;
        logic       ready;
    } rx_regs_t;

endpackage

// File: rtl/xrs_sync.sv
module xrs_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/xrs_tx_fsm.sv
module xrs_tx_fsm
    import xrs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic settled,
    input  logic fec_en,
    input  logic mark_done,
    output logic ack,
    output logic ready,
    output logic mark_start
);
    localparam tx_regs_t TX_RST = '{state: ST_IDLE_RESET, ack: 1'b0, ready: 1'b0, mark_start: 1'b0};

    tx_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE_RESET: begin
                if (req) begin
                    r_d.state = ST_ACK;
                    r_d.ack   = 1'b1;
                end
            end
            ST_ACK: begin
                if (!req) begin
                    r_d.state = ST_RELEASE;
                    r_d.ack   = 1'b0;
                end
            end
            ST_RELEASE: begin
                if (req) begin
                    r_d.state = ST_ACK;
                    r_d.ack   = 1'b1;
                end else if (settled) begin
                    if (!fec_en) begin
                        r_d.state = ST_READY;
                        r_d.ready = 1'b1;
                    end else if (!mark_done) begin
                        r_d.state      = ST_AM_WAIT;
                        r_d.mark_start = 1'b1;
                    end
                end
            end
            ST_AM_WAIT: begin
                if (req) begin
                    r_d.state      = ST_ACK;
                    r_d.ack        = 1'b1;
                    r_d.mark_start = 1'b0;
                end else if (mark_done) begin
                    r_d.state      = ST_READY;
                    r_d.ready      = 1'b1;
                    r_d.mark_start = 1'b0;
                end
            end
            ST_READY: begin
                if (req) begin
                    r_d.state = ST_ACK;
                    r_d.ack   = 1'b1;
                    r_d.ready = 1'b0;
                end
            end
            default: r_d = TX_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= TX_RST;
        else        r_q <= r_d;
    end

    assign ack        = r_q.ack;
    assign ready      = r_q.ready;
    assign mark_start = r_q.mark_start;
endmodule

// File: rtl/xrs_rx_fsm.sv
module xrs_rx_fsm
    import xrs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic settled,
    input  logic lock,
    output logic ack,
    output logic ready
);
    localparam rx_regs_t RX_RST = '{state: ST_IDLE_RESET, ack: 1'b0, ready: 1'b0};

    rx_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE_RESET: begin
                if (req) begin
                    r_d.state = ST_ACK;
                    r_d.ack   = 1'b1;
                end
            end
            ST_ACK: begin
                if (!req) begin
                    r_d.state = ST_RELEASE;
                    r_d.ack   = 1'b0;
                end
            end
            ST_RELEASE: begin
                if (req) begin
                    r_d.state = ST_ACK;
                    r_d.ack   = 1'b1;
                end else if (settled && lock) begin
                    r_d.state = ST_READY;
                    r_d.ready = 1'b1;
                end
            end
            ST_READY: begin
                if (req) begin
                    r_d.state = ST_ACK;
                    r_d.ack   = 1'b1;
                    r_d.ready = 1'b0;
                end else if (!lock) begin
                    r_d.state = ST_RELEASE;
                    r_d.ready = 1'b0;
                end
            end
            default: r_d = RX_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RX_RST;
        else        r_q <= r_d;
    end

    assign ack   = r_q.ack;
    assign ready = r_q.ready;
endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fec_en,
    input  logic tx_rst_req,
    input  logic tx_settled,
    input  logic mark_done,
    input  logic rx_rst_req,
    input  logic rx_settled,
    input  logic cdr_lock,
    output logic tx_rst_ack,
    output logic tx_ready,
    output logic mark_start,
    output logic rx_rst_ack,
    output logic rx_ready
);
    localparam int N_ASYNC = 7;

    logic [N_ASYNC-1:0] raw_in, syn_in;

    assign raw_in = {fec_en, mark_done, cdr_lock, rx_settled, tx_settled, rx_rst_req, tx_rst_req};

    xrs_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn_in)
    );

    xrs_tx_fsm u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (syn_in[0]),
        .settled    (syn_in[2]),
        .fec_en     (syn_in[6]),
        .mark_done  (syn_in[5]),
        .ack        (tx_rst_ack),
        .ready      (tx_ready),
        .mark_start (mark_start)
    );

    xrs_rx_fsm u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (syn_in[1]),
        .settled (syn_in[3]),
        .lock    (syn_in[4]),
        .ack     (rx_rst_ack),
        .ready   (rx_ready)
    );
endmodule

// File: rtl/xrs_checker.sv
module xrs_checker (
    input logic clk,
    input logic rst_n,
    input logic fec_en,
    input logic tx_rst_req,
    input logic tx_settled,
    input logic mark_done,
    input logic rx_rst_req,
    input logic rx_settled,
    input logic cdr_lock,
    input logic tx_rst_ack,
    input logic tx_ready,
    input logic mark_start,
    input logic rx_rst_ack,
    input logic rx_ready
);
    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!tx_rst_ack && !tx_ready && !mark_start && !rx_rst_ack && !rx_ready);
        end
    end

    // R4
    tx_ready_ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !tx_rst_ack);

    // R4
    tx_ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> $past(!tx_rst_ack));

    // R5
    mark_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mark_start |-> (!tx_ready && !tx_rst_ack));

    // R6
    mark_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mark_start) |-> (tx_ready || tx_rst_ack));

    // R9
    rx_ready_ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> !rx_rst_ack);

    // R9
    rx_ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(!rx_rst_ack));
endmodule

bind xcvr_rst_seq xrs_checker u_chk (.*);

// File: tb/xcvr_rst_seq_bench.sv
module xcvr_rst_seq_bench;
    localparam int STAGES = 2;
    localparam int LAT    = STAGES + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fec_en = 1'b0, tx_rst_req = 1'b0, tx_settled = 1'b0, mark_done = 1'b0;
    logic rx_rst_req = 1'b0, rx_settled = 1'b0, cdr_lock = 1'b0;
    logic tx_rst_ack, tx_ready, mark_start, rx_rst_ack, rx_ready;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    xcvr_rst_seq #(.SYNC_STAGES(STAGES)) u_xcvr_rst_seq (
        .clk(clk), .rst_n(rst_n), .fec_en(fec_en), .tx_rst_req(tx_rst_req),
        .tx_settled(tx_settled), .mark_done(mark_done), .rx_rst_req(rx_rst_req),
        .rx_settled(rx_settled), .cdr_lock(cdr_lock), .tx_rst_ack(tx_rst_ack),
        .tx_ready(tx_ready), .mark_start(mark_start), .rx_rst_ack(rx_rst_ack),
        .rx_ready(rx_ready)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic wait_e(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // one full transmit handshake; sd = 0 means settled already high
    task automatic tx_cycle(input int sd, input bit fec);
        logic pre = tx_ready;
        @(negedge clk);
        tx_settled = (sd == 0);
        tx_rst_req = 1'b1;
        wait_e(LAT - 1);
        chk("R2 tx ack early", tx_rst_ack, 1'b0);
        chk("R8 tx ready before latency", tx_ready, pre);
        wait_e(1);
        chk("R2 tx ack rise", tx_rst_ack, 1'b1);
        chk("R8 tx ready cleared", tx_ready, 1'b0);
        wait_e(8);
        chk("R2 tx ack held", tx_rst_ack, 1'b1);
        chk("R4 tx ready low in reset", tx_ready, 1'b0);
        @(negedge clk);
        tx_rst_req = 1'b0;
        wait_e(LAT - 1);
        chk("R3 tx ack early fall", tx_rst_ack, 1'b1);
        wait_e(1);
        chk("R3 tx ack fall", tx_rst_ack, 1'b0);
        if (sd != 0) begin
            wait_e(4 * sd);
            chk("R4 tx ready waits settle", tx_ready, 1'b0);
            chk("R5 mark waits settle", mark_start, 1'b0);
            @(negedge clk);
            tx_settled = 1'b1;
            wait_e(LAT - 1);
            chk("R4 tx ready early", tx_ready, 1'b0);
            chk("R5 mark early", mark_start, 1'b0);
            wait_e(1);
        end else begin
            wait_e(1);
        end
        if (!fec) begin
            chk("R4 tx ready rise", tx_ready, 1'b1);
            chk("R5 no mark without fec", mark_start, 1'b0);
        end else begin
            chk("R5 mark rise", mark_start, 1'b1);
            chk("R5 ready low with mark", tx_ready, 1'b0);
            wait_e(6);
            chk("R6 mark held", mark_start, 1'b1);
            @(negedge clk);
            mark_done = 1'b1;
            wait_e(LAT - 1);
            chk("R6 mark before done sync", mark_start, 1'b1);
            wait_e(1);
            chk("R6 mark cleared", mark_start, 1'b0);
            chk("R6 ready with clear", tx_ready, 1'b1);
            @(negedge clk);
            mark_done = 1'b0;
        end
        wait_e(5);
        chk("R3 tx ack stays low", tx_rst_ack, 1'b0);
        chk("R4 tx ready held", tx_ready, 1'b1);
    endtask

    initial begin
        #(200000 * 10);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wait_e(3);
        chk("R1 tx ack in reset", tx_rst_ack, 1'b0);
        chk("R1 tx ready in reset", tx_ready, 1'b0);
        chk("R1 mark in reset", mark_start, 1'b0);
        chk("R1 rx ack in reset", rx_rst_ack, 1'b0);
        chk("R1 rx ready in reset", rx_ready, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_e(10);
        chk("R1 tx ready idle", tx_ready, 1'b0);
        chk("R1 rx ready idle", rx_ready, 1'b0);

        // sweep over error-correction mode and settle delay
        for (int f = 0; f < 2; f++) begin
            @(negedge clk);
            fec_en = f[0];
            wait_e(2 * LAT);
            for (int sd = 0; sd < 4; sd++) tx_cycle(sd, f[0]);
        end

        // R7: marker reply still high blocks a new marker start
        @(negedge clk);
        mark_done = 1'b1;
        tx_settled = 1'b1;
        tx_rst_req = 1'b1;
        wait_e(LAT);
        chk("R8 ready drop with stale done", tx_ready, 1'b0);
        @(negedge clk);
        tx_rst_req = 1'b0;
        wait_e(LAT + 10);
        chk("R7 no mark while done high", mark_start, 1'b0);
        chk("R7 no ready while done high", tx_ready, 1'b0);
        @(negedge clk);
        mark_done = 1'b0;
        wait_e(LAT - 1);
        chk("R7 mark early", mark_start, 1'b0);
        wait_e(1);
        chk("R7 mark after done falls", mark_start, 1'b1);
        @(negedge clk);
        mark_done = 1'b1;
        wait_e(LAT);
        chk("R6 ready after done", tx_ready, 1'b1);
        @(negedge clk);
        mark_done = 1'b0;
        wait_e(LAT);

        // receive path: sweep over which of settle and lock comes last
        for (int order = 0; order < 2; order++) begin
            @(negedge clk);
            rx_settled = 1'b0;
            cdr_lock   = 1'b0;
            rx_rst_req = 1'b1;
            wait_e(LAT - 1);
            chk("R2 rx ack early", rx_rst_ack, 1'b0);
            wait_e(1);
            chk("R2 rx ack rise", rx_rst_ack, 1'b1);
            chk("R11 tx ready unaffected", tx_ready, 1'b1);
            chk("R11 tx ack unaffected", tx_rst_ack, 1'b0);
            @(negedge clk);
            rx_rst_req = 1'b0;
            wait_e(LAT);
            chk("R3 rx ack fall", rx_rst_ack, 1'b0);
            @(negedge clk);
            if (order == 0) rx_settled = 1'b1; else cdr_lock = 1'b1;
            wait_e(LAT + 8);
            chk("R9 rx ready needs both", rx_ready, 1'b0);
            @(negedge clk);
            if (order == 0) cdr_lock = 1'b1; else rx_settled = 1'b1;
            wait_e(LAT - 1);
            chk("R9 rx ready early", rx_ready, 1'b0);
            wait_e(1);
            chk("R9 rx ready rise", rx_ready, 1'b1);
        end

        // R10: lock loss and recovery
        @(negedge clk);
        cdr_lock = 1'b0;
        wait_e(LAT - 1);
        chk("R10 rx ready before loss sync", rx_ready, 1'b1);
        wait_e(1);
        chk("R10 rx ready cleared", rx_ready, 1'b0);
        wait_e(6);
        chk("R10 rx stays down", rx_ready, 1'b0);
        chk("R10 rx ack stays low", rx_rst_ack, 1'b0);
        @(negedge clk);
        cdr_lock = 1'b1;
        wait_e(LAT);
        chk("R10 rx ready back", rx_ready, 1'b1);

        // R11: transmit handshake leaves receive alone
        tx_cycle(0, 1'b1);
        chk("R11 rx ready unaffected", rx_ready, 1'b1);
        chk("R11 rx ack unaffected", rx_rst_ack, 1'b0);

        // R8 on receive: request while ready
        @(negedge clk);
        rx_rst_req = 1'b1;
        wait_e(LAT - 1);
        chk("R8 rx ready before latency", rx_ready, 1'b1);
        wait_e(1);
        chk("R8 rx ready dropped", rx_ready, 1'b0);
        chk("R8 rx ack raised", rx_rst_ack, 1'b1);
        @(negedge clk);
        rx_rst_req = 1'b0;
        wait_e(LAT + 1);
        chk("R9 rx ready after release", rx_ready, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule